// File: doc/BRIEF.md
# Micro-frame index and SOF frame counter

This block holds the running micro-frame count of a high-speed USB host controller, together with the 11-bit frame number that the host places in each start-of-frame token. A 14-bit index advances once per micro-frame, which is 125 µs long. A separate 11-bit shadow counter advances once every eight micro-frames, which is once per millisecond. The shadow steps only at the moment the low three index bits move from 3'b000 to 3'b001. As a result the index always runs one micro-frame ahead of the frame number carried on the bus.

Host software can write the index at any time through a register write strobe. Each write also loads index bits [13:3] into the shadow, so the two counters stay consistent after the write. Software must not write a value whose three low bits are 3'b111 or 3'b000.

The block also decodes the 2-bit periodic frame-list size code. From that code and the current index it produces the entry offset into the periodic frame list.

Top module: `uframe_sof_top`

## Requirements
- R1: While `rst` is high at a clock edge, both the index and the SOF frame number become 0 after that edge.
- R2: A clock edge with `tick_i`=1, `run_i`=1 and `wr_en_i`=0 increments the index by one, modulo 2^14. The value 16383 therefore wraps to 0.
- R3: When `run_i` is 0, `tick_i` has no effect. The index and the SOF frame number both hold their values.
- R4: On an accepted tick (as defined in R2), the SOF frame number increments by one, modulo 2^11, exactly when index bits [2:0] are 3'b000 before the edge, which takes them to 3'b001. On every other accepted tick the SOF frame number holds.
- R5: A clock edge with `wr_en_i`=1 loads `wr_data_i` into the index and `wr_data_i[13:3]` into the SOF frame number. This happens whatever the state of `run_i`.
- R6: When a write and an accepted tick occur in the same cycle, the write wins. The tick is dropped: no increment is applied to either counter.
- R7: `list_off_o` is combinational from the current index and `fls_i`, as follows:
  - Codes 2'b00 (1024 entries) and the reserved code 2'b11 give index[12:3].
  - Code 2'b01 (512 entries) gives index[11:3], with bit 9 of the output forced to 0.
  - Code 2'b10 (256 entries) gives index[10:3], with bits 9:8 of the output forced to 0.
- R8: Counting from a written index whose low bits are 3'b001, the SOF frame number equals index[13:3] whenever the index low bits are not 3'b000. Over eight accepted ticks it advances by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse at each micro-frame boundary |
| run_i | input | 1 | Counting enable |
| wr_en_i | input | 1 | Index register write strobe |
| wr_data_i | input | 14 | Value written to the index |
| fls_i | input | 2 | Periodic frame-list size code |
| uf_index_o | output | 14 | Current micro-frame index |
| sof_frame_o | output | 11 | Frame number for the SOF token |
| list_off_o | output | 10 | Periodic frame-list entry offset |

## Verification
Both counters are visible as registered outputs, so a wrong increment, a missed hold or a bad load shows on the very next clock edge. The bench therefore compares them after every cycle of stimulus. A shadow that steps on the wrong low-bit transition first departs from the expected value within eight ticks, and the sequences here cover whole eight-tick groups and both wrap points. An offset masking error shows in the same cycle as the index value that exposes it, which is why every index tested is read under each size code.

// File: rtl/mfidx_pkg.sv
package mfidx_pkg;

    localparam int IDX_W = 14;
    localparam int SOF_W = IDX_W - 3;
    localparam int OFF_W = IDX_W - 4;

    typedef logic [IDX_W-1:0] uf_idx_t;
    typedef logic [SOF_W-1:0] sof_num_t;
    typedef logic [OFF_W-1:0] list_off_t;

    typedef enum logic [1:0] {
        LSZ_1024 = 2'b00,
        LSZ_512  = 2'b01,
        LSZ_256  = 2'b10,
        LSZ_RSVD = 2'b11
    } list_size_e;

    typedef struct packed {
        logic    load;
        uf_idx_t data;
    } idx_wr_t;

    // number of offset bits kept for a size code (log2 of entry count)
    function automatic int unsigned entry_bits(input list_size_e sz);
        case (sz)
            LSZ_512: return 9;
            LSZ_256: return 8;
            default: return 10;
        endcase
    endfunction

    function automatic list_off_t entry_mask(input list_size_e sz);
        list_off_t m;
        for (int b = 0; b < OFF_W; b++) begin
            m[b] = (b < entry_bits(sz));
        end
        return m;
    endfunction

endpackage

// File: rtl/uf_index_ctr.sv
module uf_index_ctr
    import mfidx_pkg::*;
#(
    parameter int W = IDX_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    input  logic         run_i,
    input  idx_wr_t      wr_i,
    output logic [W-1:0] idx_o,
    output logic         step_o
);
    logic [W-1:0] idx_q;

    // a write always beats a tick in the same cycle
    assign step_o = tick_i & run_i & ~wr_i.load;

    always_ff @(posedge clk) begin
        if (rst)
            idx_q <= '0;
        else if (wr_i.load)
            idx_q <= wr_i.data[W-1:0];
        else if (step_o)
            idx_q <= idx_q + 1'b1;
    end

    assign idx_o = idx_q;

    AST_IDX_RST_CLR: assert property (@(posedge clk) rst |=> idx_q == '0); // R1
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick_i && run_i && !wr_i.load) |=> idx_q == W'($past(idx_q) + 1'b1)); // R2
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run_i && !wr_i.load) |=> $stable(idx_q)); // R3
    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_i.load |=> idx_q == $past(wr_i.data[W-1:0])); // R6

endmodule

// File: rtl/sof_shadow_ctr.sv
module sof_shadow_ctr
    import mfidx_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int SW = IW - 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step_i,
    input  logic [2:0]    idx_low_i,
    input  idx_wr_t       wr_i,
    output logic [SW-1:0] sof_o
);
    logic [SW-1:0] sof_q;
    logic          bump;

    // low bits about to go 000 -> 001
    assign bump = step_i && (idx_low_i == 3'b000);

    always_ff @(posedge clk) begin
        if (rst)
            sof_q <= '0;
        else if (wr_i.load)
            sof_q <= wr_i.data[IW-1:3];
        else if (bump)
            sof_q <= sof_q + 1'b1;
    end

    assign sof_o = sof_q;

    AST_SOF_RST_CLR: assert property (@(posedge clk) rst |=> sof_q == '0); // R1
    AST_SOF_ADV: assert property (@(posedge clk) disable iff (rst)
        (step_i && idx_low_i == 3'b000) |=> sof_q == SW'($past(sof_q) + 1'b1)); // R4
    AST_SOF_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!wr_i.load && !(step_i && idx_low_i == 3'b000)) |=> $stable(sof_q)); // R4
    AST_SOF_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_i.load |=> sof_q == $past(wr_i.data[IW-1:3])); // R5

endmodule

// File: rtl/flist_offset.sv
module flist_offset
    import mfidx_pkg::*;
#(
    parameter int IW = IDX_W,
    parameter int OW = IW - 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] idx_i,
    input  logic [1:0]    size_i,
    output logic [OW-1:0] off_o
);
    list_size_e sz;
    list_off_t  mask;
    logic [OW-1:0] raw;

    assign sz   = list_size_e'(size_i);
    assign mask = entry_mask(sz);

    generate
        for (genvar g = 0; g < OW; g++) begin : g_bit
            assign raw[g]   = idx_i[g+3];
            assign off_o[g] = raw[g] & mask[g];
        end
    endgenerate

    AST_OFF_512: assert property (@(posedge clk) disable iff (rst)
        (size_i == 2'b01) |-> (off_o[OW-1] == 1'b0 && off_o[OW-2:0] == idx_i[OW+1:3])); // R7
    AST_OFF_256: assert property (@(posedge clk) disable iff (rst)
        (size_i == 2'b10) |-> (off_o[OW-1:OW-2] == 2'b00)); // R7
    AST_OFF_FULL: assert property (@(posedge clk) disable iff (rst)
        (size_i == 2'b00 || size_i == 2'b11) |-> off_o == idx_i[OW+2:3]); // R7

endmodule

// File: rtl/uframe_sof_top.sv
module uframe_sof_top
    import mfidx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        run_i,
    input  logic        wr_en_i,
    input  logic [13:0] wr_data_i,
    input  logic [1:0]  fls_i,
    output logic [13:0] uf_index_o,
    output logic [10:0] sof_frame_o,
    output logic [9:0]  list_off_o
);
    idx_wr_t wr;
    logic    step;

    assign wr.load = wr_en_i;
    assign wr.data = wr_data_i;

    uf_index_ctr #(.W(IDX_W)) u_idx (
        .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(run_i),
        .wr_i(wr), .idx_o(uf_index_o), .step_o(step)
    );

    sof_shadow_ctr #(.IW(IDX_W)) u_sof (
        .clk(clk), .rst(rst), .step_i(step), .idx_low_i(uf_index_o[2:0]),
        .wr_i(wr), .sof_o(sof_frame_o)
    );

    flist_offset #(.IW(IDX_W)) u_off (
        .clk(clk), .rst(rst), .idx_i(uf_index_o), .size_i(fls_i),
        .off_o(list_off_o)
    );

    AST_TICK_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && tick_i && run_i) |=> sof_frame_o == $past(wr_data_i[13:3])); // R6

endmodule

// File: tb/sim_uframe_sof_top.sv
module sim_uframe_sof_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0, run_i = 1'b0, wr_en_i = 1'b0;
    logic [13:0] wr_data_i = '0;
    logic [1:0]  fls_i = 2'b00;
    logic [13:0] uf_index_o;
    logic [10:0] sof_frame_o;
    logic [9:0]  list_off_o;

    int n_run = 0, n_fail = 0;
    logic [13:0] e_idx = '0;
    logic [10:0] e_sof = '0;

    always #10 clk = ~clk;

    uframe_sof_top u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, update model, compare at next negedge
    task automatic cyc(input logic t, input logic r, input logic w, input logic [13:0] d);
        tick_i = t; run_i = r; wr_en_i = w; wr_data_i = d;
        if (w) begin
            e_idx = d; e_sof = d[13:3];
        end else if (t && r) begin
            if (e_idx[2:0] == 3'b000) e_sof = e_sof + 11'd1;
            e_idx = e_idx + 14'd1;
        end
        @(negedge clk);
        tick_i = 0; wr_en_i = 0;
    endtask

    task automatic cmp(input string req);
        chk({req, " index"}, int'(uf_index_o), int'(e_idx));
        chk({req, " sof"}, int'(sof_frame_o), int'(e_sof));
    endtask

    function automatic int exp_off(input logic [13:0] ix, input logic [1:0] s);
        case (s)
            2'b01:   return int'(ix[11:3]);
            2'b10:   return int'(ix[10:3]);
            default: return int'(ix[12:3]);
        endcase
    endfunction

    task automatic t_reset();
        cyc(1, 1, 1, 14'h1234);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        e_idx = '0; e_sof = '0;
        cmp("R1");
    endtask

    task automatic t_count();
        for (int i = 0; i < 20; i++) begin
            cyc(1, 1, 0, '0);
            cmp("R2/R4");
        end
        chk("R4 value after 20 ticks", int'(sof_frame_o), 3);
    endtask

    task automatic t_run_low();
        logic [13:0] hi = uf_index_o;
        logic [10:0] hs = sof_frame_o;
        for (int i = 0; i < 5; i++) cyc(1, 0, 0, '0);
        chk("R3 index held", int'(uf_index_o), int'(hi));
        chk("R3 sof held", int'(sof_frame_o), int'(hs));
    endtask

    task automatic t_write();
        cyc(0, 0, 1, 14'h0A5A);
        cmp("R5 write run low");
        chk("R5 sof=data[13:3]", int'(sof_frame_o), 14'h0A5A >> 3);
        cyc(0, 1, 1, 14'h1F09);
        cmp("R5 write run high");
    endtask

    task automatic t_collision();
        cyc(1, 1, 1, 14'h0010 | 14'h0001);
        chk("R6 index", int'(uf_index_o), 17);
        chk("R6 sof", int'(sof_frame_o), 2);
        cyc(1, 1, 1, 14'h0201);
        chk("R6 index again", int'(uf_index_o), 14'h0201);
    endtask

    task automatic t_lockstep();
        cyc(0, 1, 1, 14'h0321);
        for (int i = 0; i < 24; i++) begin
            cyc(1, 1, 0, '0);
            if (uf_index_o[2:0] != 3'b000)
                chk("R8 sof tracks index[13:3]", int'(sof_frame_o), int'(uf_index_o[13:3]));
        end
        chk("R8 three frames advanced", int'(sof_frame_o), (14'h0321 >> 3) + 3);
    endtask

    task automatic t_wrap();
        cyc(0, 1, 1, 14'h3FF9);
        chk("R5 sof loaded 2047", int'(sof_frame_o), 2047);
        for (int i = 0; i < 6; i++) cyc(1, 1, 0, '0);
        chk("R2 at top", int'(uf_index_o), 16383);
        cyc(1, 1, 0, '0);
        chk("R2 index wrap", int'(uf_index_o), 0);
        chk("R4 no step on 111->000", int'(sof_frame_o), 2047);
        cyc(1, 1, 0, '0);
        chk("R4 sof wrap", int'(sof_frame_o), 0);
        cmp("R2/R4 after wrap");
    endtask

    task automatic t_offset();
        logic [13:0] pats [4] = '{14'h3FFF, 14'h1F58, 14'h0AB1, 14'h2C0F};
        foreach (pats[p]) begin
            cyc(0, 0, 1, pats[p]);
            for (int s = 0; s < 4; s++) begin
                fls_i = 2'(s);
                #1;
                chk($sformatf("R7 size %0d", s), int'(list_off_o), exp_off(pats[p], 2'(s)));
            end
        end
        fls_i = 2'b00;
    endtask

    initial begin
        fork
            begin
                @(negedge clk); @(negedge clk);
                rst = 1'b0;
                chk("R1 reset index", int'(uf_index_o), 0);
                chk("R1 reset sof", int'(sof_frame_o), 0);
                t_count();
                t_run_low();
                t_write();
                t_collision();
                t_lockstep();
                t_wrap();
                t_offset();
                t_reset();
            end
            begin
                repeat (5000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule